// File: doc/BRIEF.md
# Fractional Root Clock Generator

This block derives one output clock from a choice of eight source clocks. It divides first by a pre-divider that can step in half-source-cycle units. It can then apply an M/N fractional divider whose high time is programmable. Each source is modelled as an enable strobe in the single system clock domain. One strobe marks one source half-cycle, so a source's rate is half its strobe rate. The output `clk_out` is a level that changes only on strobes of the selected source.

Software writes shadow copies of the configuration word and the M, N and D values through a small synchronous write port with combinational read-back. Nothing written to the shadows reaches the output until software sets the update bit in the command register. The block then copies all shadows into the active set in one cycle, at a moment when the output is low, and clears the update bit. The new waveform starts fresh from the first strobe of the newly selected source.

Register addresses on `bus_addr` are: 0 = configuration, 1 = command, 2 = M, 3 = N, 4 = D. M, N and D are 8 bits wide by default (parameter `MW`).

Top module: `rcg_mnd`

## Requirements
- R1: During and after reset `clk_out` is low, every register reads 0 and no update is pending. The reset configuration is bypass mode with divide-by-one on source 0, so the output period is 2 strobes and its high time is 1 strobe.
- R2: Configuration bits [10:8] select which bit of `src_tick` drives the generator. `clk_out` changes only in the cycle after a strobe of the active source.
- R3: Configuration bits [4:0] hold the pre-divide code h. In bypass mode the output period is hh+1 strobes and the output is high for ceil((hh+1)/2) strobes, where hh = h, except that hh = 1 when h = 0. For example, h = 4 divides by 2.5 source cycles.
- R4: The M register holds M directly. The N register holds the 8-bit inverse of (N − M), so the effective N is (~Nreg + M) mod 256. Software keeps M < N.
- R5: The D register holds the 8-bit inverse of twice the duty count. In M/N mode, each pre-divided period advances a counter by M modulo N, and the output is high while 2·count < ~Dreg. With M = 1 the output period is N·(hh+1) strobes.
- R6: With M > 1 the waveform is fractional. Over N pre-divided periods there are M rising edges. For M = 2, N = 5 and ~Dreg = 4, two consecutive periods together last 5·(hh+1) strobes and are high for 2·(hh+1) strobes.
- R7: The M/N stage is active only when the N register is nonzero and configuration bits [13:12] equal 2. Otherwise the output follows R3.
- R8: The configuration register stores and reads back all 32 bits. Bits [31:14] and bits [7:5] and [11] have no effect on the output.
- R9: Writes to the configuration, M, N or D registers do not change the output until an update is committed.
- R10: Writing the command register with bit 0 set makes bit 0 read 1. Writing it with bit 0 clear has no effect. The shadows are committed at the first clock edge where the update bit is set and `clk_out` is low. From the next cycle bit 0 reads 0.
- R11: A shadow register write in the commit cycle is not part of that commit; it stays in the shadow. A command write with bit 0 set in the commit cycle leaves the update pending.
- R12: After a commit the output stays low until the first strobe of the new source. That strobe starts a new period from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 8 | Per-source half-cycle strobes |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| clk_out | output | 1 | Generated clock level |

## Verification
The commit of the shadow set and a software register write can land on the same clock edge. The bench provokes this by waiting for a falling edge of the output, which guarantees a long low phase. It writes the update bit, and on the very next edge writes either a new M value or the update bit again. The M case passes when the measured output period still reflects the old M while M reads back the new value. The repeated update case passes when the update bit still reads 1 after the collision and then clears.

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    src_tick,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          clk_out
);
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_M = 3'd2, A_N = 3'd3, A_D = 3'd4;
  localparam logic [1:0] MODE_DUAL = 2'd2;

  logic [31:0]   sh_cfg;
  logic [MW-1:0] sh_m, sh_n, sh_d;
  logic          upd_pend;

  logic [4:0]    ac_div;
  logic [2:0]    ac_sel;
  logic [1:0]    ac_mode;
  logic [MW-1:0] ac_m, ac_n, ac_d;

  logic [4:0]    pc;
  logic [MW-1:0] cnt;
  logic          out_q;

  wire [4:0]    hh     = (ac_div == 5'd0) ? 5'd1 : ac_div;
  wire [4:0]    hh_sh  = (sh_cfg[4:0] == 5'd0) ? 5'd1 : sh_cfg[4:0];
  wire          tick   = src_tick[ac_sel];
  wire [MW-1:0] n_eff  = ~ac_n + ac_m;
  wire          mnd_on = (ac_n != '0) && (ac_mode == MODE_DUAL);
  wire          commit = upd_pend && !out_q;
  wire          wrap   = (pc == hh);
  wire [4:0]    pc_nx  = wrap ? 5'd0 : pc + 5'd1;
  wire [MW:0]   sum    = {1'b0, cnt} + {1'b0, ac_m};
  wire [MW:0]   dif    = sum - {1'b0, n_eff};
  wire [MW-1:0] cnt_nx = !wrap ? cnt : ((sum >= {1'b0, n_eff}) ? dif[MW-1:0] : sum[MW-1:0]);
  wire [MW:0]   dval2  = {1'b0, ~ac_d};
  wire          hi_mnd = ({cnt_nx, 1'b0} < dval2);
  wire          hi_byp = ({pc_nx, 1'b0} < ({1'b0, hh} + 6'd1));
  wire          wr_cmd = bus_we && (bus_addr == A_CMD) && bus_wdata[0];

  assign clk_out = out_q;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = sh_cfg;
      A_CMD:   bus_rdata = {31'd0, upd_pend};
      A_M:     bus_rdata = 32'(sh_m);
      A_N:     bus_rdata = 32'(sh_n);
      A_D:     bus_rdata = 32'(sh_d);
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cfg <= '0;
      sh_m   <= '0;
      sh_n   <= '0;
      sh_d   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CFG:   sh_cfg <= bus_wdata;
        A_M:     sh_m   <= bus_wdata[MW-1:0];
        A_N:     sh_n   <= bus_wdata[MW-1:0];
        A_D:     sh_d   <= bus_wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      upd_pend <= 1'b0;
    else if (wr_cmd) upd_pend <= 1'b1;
    else if (commit) upd_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_div  <= '0;
      ac_sel  <= '0;
      ac_mode <= '0;
      ac_m    <= '0;
      ac_n    <= '0;
      ac_d    <= '0;
      pc      <= 5'd1;
      cnt     <= '0;
      out_q   <= 1'b0;
    end else if (commit) begin
      ac_div  <= sh_cfg[4:0];
      ac_sel  <= sh_cfg[10:8];
      ac_mode <= sh_cfg[13:12];
      ac_m    <= sh_m;
      ac_n    <= sh_n;
      ac_d    <= sh_d;
      pc      <= hh_sh;
      cnt     <= ~sh_n;
    end else if (tick) begin
      pc    <= pc_nx;
      cnt   <= cnt_nx;
      out_q <= mnd_on ? hi_mnd : hi_byp;
    end
  end
endmodule

module rcg_mnd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_out,
  input logic       pend,
  input logic       tick,
  input logic       we,
  input logic [2:0] addr,
  input logic       wd0
);
  // R10: a commit only happens while the output is low
  a_r10_commit_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> !$past(clk_out));
  // R10: a pending update with a low output is taken at once
  a_r10_commit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clk_out && !(we && addr == 3'd1 && wd0)) |=> !pend);
  // R11: an update request is never lost
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 3'd1 && wd0) |=> pend);
  // R12: no pulse directly after a commit
  a_r12_low_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> !clk_out);
  // R2: the output only moves after a strobe of the active source
  a_r2_out_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(tick));
endmodule

bind rcg_mnd rcg_mnd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .pend(upd_pend), .tick(tick),
  .we(bus_we), .addr(bus_addr), .wd0(bus_wdata[0])
);

// File: tb/sim_rcg_mnd.sv
`timescale 1ns/1ps
module sim_rcg_mnd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  rcg_mnd u0 (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_we(bus_we),
              .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
              .clk_out(clk_out));

  always #2.5 clk = ~clk;

  // source i strobes once every i+2 system cycles
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 8; i++) src_tick[i] = ((cyc % (i + 2)) == 0);
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_upd(input string tag);
    int v;
    wr(3'd1, 32'd1);
    rd(3'd1, v);
    chk({tag, " R10 update bit set"}, v, 1);
    for (int i = 0; i < 500; i++) begin
      rd(3'd1, v);
      if (v == 0) break;
      @(negedge clk);
    end
    chk({tag, " R10 update bit cleared"}, v, 0);
  endtask

  task automatic prog(input logic [31:0] c, input int m, input int n, input int d);
    wr(3'd0, c);
    wr(3'd2, 32'(m));
    wr(3'd3, 32'(n));
    wr(3'd4, 32'(d));
  endtask

  task automatic wait_fall();
    logic p;
    p = clk_out;
    forever begin
      @(negedge clk);
      if (p && !clk_out) break;
      p = clk_out;
    end
  endtask

  // measures k rise-to-rise intervals starting at the next rising edge
  task automatic measure(input int k, output int per, output int hi);
    logic p, c;
    int rises;
    p = clk_out;
    forever begin
      @(negedge clk);
      if (clk_out && !p) break;
      p = clk_out;
    end
    per = 1; hi = 1; rises = 0; c = 1'b1;
    forever begin
      @(negedge clk);
      p = c; c = clk_out;
      if (c && !p) rises++;
      if (rises == k) break;
      per++;
      if (c) hi++;
    end
  endtask

  task automatic t_reset();
    int v, per, hi;
    chk("R1 output low in reset", int'(clk_out), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reads zero", v, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    measure(1, per, hi);
    chk("R1 default period", per, 4);
    chk("R1 default high time", hi, 2);
  endtask

  task automatic t_bypass();
    int per, hi;
    prog(32'h0000_0204, 0, 0, 0);
    wait_upd("bypass h4");
    measure(1, per, hi);
    chk("R3 half-step period h=4 src2", per, 20);
    chk("R3 half-step high h=4 src2", hi, 12);
    prog(32'h0000_0307, 0, 0, 0);
    wait_upd("bypass h7");
    measure(1, per, hi);
    chk("R2 period h=7 src3", per, 40);
    chk("R2 high h=7 src3", hi, 20);
  endtask

  task automatic t_shadow_only();
    int per, hi, v;
    prog(32'h0000_2101, 9, 8'h55, 8'h33);
    wr(3'd1, 32'd0);
    rd(3'd1, v);
    chk("R10 zero command ignored", v, 0);
    measure(1, per, hi);
    chk("R9 shadow writes do not move period", per, 40);
    chk("R9 shadow writes do not move high", hi, 20);
    rd(3'd2, v);
    chk("R9 shadow M reads back", v, 9);
  endtask

  task automatic t_mnd();
    int per, hi;
    prog(32'h0000_2101, 1, 8'hFC, 8'hFB);
    wait_upd("mnd 1/4");
    measure(1, per, hi);
    chk("R4 M/N period N=4", per, 24);
    chk("R5 M/N high 2d=4", hi, 12);
    prog(32'h0000_2003, 1, 8'hFA, 8'hFD);
    wait_upd("mnd 1/6");
    measure(1, per, hi);
    chk("R5 narrow period N=6", per, 48);
    chk("R5 narrow high 2d=2", hi, 8);
  endtask

  task automatic t_mode_upper();
    int per, hi, v;
    prog(32'hFFFF_C8E3, 1, 8'hFA, 8'hFD);
    wait_upd("mode0");
    measure(1, per, hi);
    chk("R7 mode 0 forces bypass period", per, 8);
    chk("R7 mode 0 forces bypass high", hi, 4);
    rd(3'd0, v);
    chk("R8 full config readback", v, 32'hFFFF_C8E3);
    wr(3'd0, 32'hFFFF_E101);
    wait_upd("mode2 upper");
    measure(1, per, hi);
    chk("R8 upper bits ignored period", per, 36);
    chk("R8 upper bits ignored high", hi, 6);
  endtask

  task automatic t_collide();
    int per, hi, v;
    prog(32'h0000_2101, 1, 8'hFC, 8'hFB);
    wait_upd("collide setup");
    wait_fall();
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd2);
    rd(3'd1, v);
    chk("R11 commit done in write cycle", v, 0);
    rd(3'd2, v);
    chk("R11 late M stays in shadow", v, 2);
    measure(1, per, hi);
    chk("R11 committed old M period", per, 24);
    chk("R12 fresh start high time", hi, 12);
    wait_fall();
    wr(3'd1, 32'd1);
    wr(3'd1, 32'd1);
    rd(3'd1, v);
    chk("R11 command in commit cycle keeps pending", v, 1);
    @(negedge clk);
    rd(3'd1, v);
    chk("R11 second commit follows", v, 0);
  endtask

  task automatic t_frac();
    int per, hi;
    measure(2, per, hi);
    chk("R6 fractional two-period span M=2 N=5", per, 30);
    chk("R6 fractional two-period high", hi, 12);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass();
    t_shadow_only();
    t_mnd();
    t_mode_upper();
    t_collide();
    t_frac();
    finish_sim();
  end
endmodule